// File: doc/BRIEF.md
# Dual-Link LVDS Pixel Packer and Serializer

This block turns a parallel 24-bit RGB pixel stream into the logical bit streams of a two-link LVDS display interface. Each link has four data lanes. Each lane carries seven bits per pixel period, which gives 28 bit slots per pixel. These slots hold eight bits of each colour, the data-enable flag and three reserved bits. The block also produces a clock-lane pattern for each link, aligned to the data frame. Link 0 carries the even pixel of each pair and link 1 carries the odd pixel. The analog drivers and the PLL that makes the fast clock are outside the block.

The whole block runs on the 7x serial clock. A divide-by-seven phase counter produces `pix_ce`, which marks the one fast cycle in seven whose closing edge captures the pixel inputs. The upstream logic drives the pixel bus during that cycle.

A format-select input chooses between two slot arrangements:
- **Standard:** the six low colour bits go to the main slots and the two top bits go to the spare slots.
- **Shifted:** the top six colour bits go to the main slots and the two low bits go to the spare slots.

The select is taken only at captures made while `frame_blank` is high, so a frame is never sent with a mix of the two arrangements.

Top module: `lvds_dual_packer`

## Requirements
- R1: Lane k of a link carries slots 7k to 7k+6. Slot 7k+j appears on the lane in the (j+1)-th fast cycle after the capturing edge, so the lowest-numbered slot goes out first.
- R2: In standard format (active select 0), the slots are filled as follows:
  - red bits 0..5 go to slots 0,1,2,3,4,6;
  - green bits 0..5 go to slots 7,8,9,12,13,14;
  - blue bits 0..5 go to slots 15,18,19,20,21,22;
  - red bits 6,7 go to slots 27,5; green bits 6,7 go to slots 10,11; blue bits 6,7 go to slots 16,17.
- R3: In shifted format (active select 1), the slots that carried colour bits 0..5 carry bits 2..7, and the two spare slots of each colour carry bits 0,1 in the same order.
- R4: Slot 26 carries the data-enable bit of the captured pixel in both formats.
- R5: Slots 23, 24 and 25 always carry the constant RSVD_LEVEL (default 0).
- R6: Each clock lane sends the 7-bit sequence 1,1,0,0,0,1,1 in the same seven fast cycles as its link's data frame.
- R7: `pix_ce` is high for exactly one fast cycle in every seven. The pixel inputs are captured at the rising edge that ends that cycle.
- R8: At a capture with `frame_blank` high, the active format becomes `fmt_sel` and is used for that pixel. At a capture with `frame_blank` low, the active format is kept and `fmt_sel` has no effect. After reset the active format is standard.
- R9: During and after reset, up to the first capture, all serial outputs and `pix_ce` are 0.
- R10: The pixel bus packs red in bits [23:16], green in [15:8] and blue in [7:0] of each 24-bit field:
  - link 0 uses `pix_rgb[23:0]` and `pix_de[0]`;
  - link 1 uses `pix_rgb[47:24]` and `pix_de[1]`;
  - link l drives `ser_data[4l+3:4l]` (lane k on bit 4l+k) and `ser_clk[l]`;
  - the two links are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serial clock, seven times the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_rgb | input | 48 | Even pixel in [23:0], odd pixel in [47:24], each packed {R,G,B} |
| pix_de | input | 2 | Data enable per link |
| fmt_sel | input | 1 | Requested slot arrangement: 0 standard, 1 shifted |
| frame_blank | input | 1 | High during vertical blanking; gates format changes |
| pix_ce | output | 1 | Pixel-rate strobe; inputs are captured at the edge that ends it |
| ser_data | output | 8 | Serial data lanes, four per link |
| ser_clk | output | 2 | Clock-lane pattern per link |

## Verification
The embedded assertions check the following on every cycle:
- the strobe never stays high for two cycles in a row, and the phase stays in range;
- the bit loaded into a lane appears on its output one cycle later;
- the clock-lane levels at fixed offsets from each load are correct;
- the reserved slot levels on lane 3 are correct;
- the active format is held across every capture made outside blanking.

The full slot arrangement in both formats, the lane order, the data-enable slot, the independence of the two links and the rule that `fmt_sel` is ignored outside blanking are shown only by the bench. The bench reassembles each serial frame and compares it with a slot table that it builds on its own.

// File: rtl/lvds_pkg.sv
package lvds_pkg;
  localparam int COLOR_W   = 8;
  localparam int PIX_W     = 3 * COLOR_W;
  localparam int LANES     = 4;
  localparam int LANE_BITS = 7;
  localparam int SLOTS     = LANES * LANE_BITS;

  // clock-lane word; bit 0 is sent first
  localparam logic [LANE_BITS-1:0] CLK_WORD = 7'b1100011;

  // main (six-bit) part of one colour for the chosen arrangement
  function automatic logic [5:0] main_part(input logic [COLOR_W-1:0] c, input logic alt);
    return alt ? c[7:2] : c[5:0];
  endfunction

  // spare (two-bit) part of one colour for the chosen arrangement
  function automatic logic [1:0] spare_part(input logic [COLOR_W-1:0] c, input logic alt);
    return alt ? c[1:0] : c[7:6];
  endfunction

  // place one pixel onto the 28 slot positions
  function automatic logic [SLOTS-1:0] pack_slots(input logic [PIX_W-1:0] rgb,
                                                  input logic de,
                                                  input logic alt,
                                                  input logic rsvd);
    logic [5:0] rm, gm, bm;
    logic [1:0] rs, gs, bs;
    logic [SLOTS-1:0] w;
    rm = main_part(rgb[23:16], alt);
    gm = main_part(rgb[15:8], alt);
    bm = main_part(rgb[7:0], alt);
    rs = spare_part(rgb[23:16], alt);
    gs = spare_part(rgb[15:8], alt);
    bs = spare_part(rgb[7:0], alt);
    w         = '0;
    w[4:0]    = rm[4:0];
    w[6]      = rm[5];
    w[27]     = rs[0];
    w[5]      = rs[1];
    w[9:7]    = gm[2:0];
    w[14:12]  = gm[5:3];
    w[10]     = gs[0];
    w[11]     = gs[1];
    w[15]     = bm[0];
    w[22:18]  = bm[5:1];
    w[16]     = bs[0];
    w[17]     = bs[1];
    w[25:23]  = {3{rsvd}};
    w[26]     = de;
    return w;
  endfunction
endpackage

// File: rtl/lvds_phase_gen.sv
module lvds_phase_gen #(
  parameter int RATIO = 7
) (
  input  logic clk,
  input  logic rst_n,
  output logic ce
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n)          ph <= '0;
    else if (ph == LAST) ph <= '0;
    else                 ph <= ph + 1'b1;
  end

  assign ce = (ph == LAST);

  // R7: the strobe is a single-cycle pulse
  assert_ce_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> !ce);

  // R7: the phase never leaves its range
  assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= LAST);
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] word,
  output logic         sout
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)  sh <= '0;
    else if (ld) sh <= word;
    else         sh <= {1'b0, sh[W-1:1]};
  end

  assign sout = sh[0];

  // R1: the lowest slot of the word leads the frame
  assert_first_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (sout == $past(word[0])));
endmodule

// File: rtl/lvds_link.sv
module lvds_link
  import lvds_pkg::*;
#(
  parameter logic RSVD_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             frame_blank,
  input  logic             fmt_sel,
  input  logic [PIX_W-1:0] rgb,
  input  logic             de,
  output logic [LANES-1:0] lane_o,
  output logic             clk_o
);
  logic fmt_act;
  logic fmt_use;
  logic fmt_take;
  logic [SLOTS-1:0] slots;

  assign fmt_take = ld && frame_blank;
  assign fmt_use  = frame_blank ? fmt_sel : fmt_act;

  always_ff @(posedge clk) begin
    if (!rst_n)  fmt_act <= 1'b0;
    else if (ld) fmt_act <= fmt_use;
  end

  assign slots = pack_slots(rgb, de, fmt_use, RSVD_LEVEL);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lvds_lane_shifter #(.W(LANE_BITS)) u_sh (
      .clk  (clk),
      .rst_n(rst_n),
      .ld   (ld),
      .word (slots[k*LANE_BITS +: LANE_BITS]),
      .sout (lane_o[k])
    );
  end

  lvds_lane_shifter #(.W(LANE_BITS)) u_clk_sh (
    .clk  (clk),
    .rst_n(rst_n),
    .ld   (ld),
    .word (CLK_WORD),
    .sout (clk_o)
  );

  // R8: the active format only moves at a capture inside blanking
  assert_fmt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_take |=> $stable(fmt_act));

  // R6: clock lane is high in the first two bits of a frame and low in the third
  assert_clk_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld) |-> clk_o);
  assert_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld, 3) |-> !clk_o);

  // R5: lane 3 bits 2..4 are the reserved slots
  assert_rsvd_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld, 3) |-> (lane_o[3] == RSVD_LEVEL));
  assert_rsvd_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld, 5) |-> (lane_o[3] == RSVD_LEVEL));
endmodule

// File: rtl/lvds_dual_packer.sv
module lvds_dual_packer
  import lvds_pkg::*;
#(
  parameter int   LINKS      = 2,
  parameter logic RSVD_LEVEL = 1'b0
) (
  input  logic                   clk_fast,
  input  logic                   rst_n,
  input  logic [LINKS*PIX_W-1:0] pix_rgb,
  input  logic [LINKS-1:0]       pix_de,
  input  logic                   fmt_sel,
  input  logic                   frame_blank,
  output logic                   pix_ce,
  output logic [LINKS*LANES-1:0] ser_data,
  output logic [LINKS-1:0]       ser_clk
);
  lvds_phase_gen #(.RATIO(LANE_BITS)) u_phase (
    .clk  (clk_fast),
    .rst_n(rst_n),
    .ce   (pix_ce)
  );

  for (genvar l = 0; l < LINKS; l++) begin : g_link
    lvds_link #(.RSVD_LEVEL(RSVD_LEVEL)) u_link (
      .clk        (clk_fast),
      .rst_n      (rst_n),
      .ld         (pix_ce),
      .frame_blank(frame_blank),
      .fmt_sel    (fmt_sel),
      .rgb        (pix_rgb[l*PIX_W +: PIX_W]),
      .de         (pix_de[l]),
      .lane_o     (ser_data[l*LANES +: LANES]),
      .clk_o      (ser_clk[l])
    );
  end

  // R9: nothing toggles before the first capture after reset
  assert_quiet_after_reset_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ($past(!rst_n) && rst_n) |-> (ser_data == '0 && ser_clk == '0));
endmodule

// File: tb/sim_lvds_dual_packer.sv
module sim_lvds_dual_packer;
  localparam int PERIOD = 10;

  logic        clk_fast = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] pix_rgb = '0;
  logic [1:0]  pix_de = '0;
  logic        fmt_sel = 1'b0;
  logic        frame_blank = 1'b0;
  logic        pix_ce;
  logic [7:0]  ser_data;
  logic [1:0]  ser_clk;

  lvds_dual_packer u0 (
    .clk_fast(clk_fast), .rst_n(rst_n), .pix_rgb(pix_rgb), .pix_de(pix_de),
    .fmt_sel(fmt_sel), .frame_blank(frame_blank), .pix_ce(pix_ce),
    .ser_data(ser_data), .ser_clk(ser_clk)
  );

  always #(PERIOD/2) clk_fast = ~clk_fast;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slot tables restated from the requirements
  int main_slot [3][6] = '{'{0,1,2,3,4,6}, '{7,8,9,12,13,14}, '{15,18,19,20,21,22}};
  int spare_slot[3][2] = '{'{27,5}, '{10,11}, '{16,17}};

  function automatic logic [27:0] expect_word(input logic [23:0] rgb, input logic de, input logic alt);
    logic [27:0] e;
    logic [7:0] col;
    e = '0;
    for (int c = 0; c < 3; c++) begin
      col = rgb[23 - 8*c -: 8];
      for (int i = 0; i < 6; i++) e[main_slot[c][i]] = col[alt ? i + 2 : i];
      for (int i = 0; i < 2; i++) e[spare_slot[c][i]] = col[alt ? i : i + 6];
    end
    e[26] = de;
    return e;
  endfunction

  typedef struct {
    logic [27:0] w0;
    logic [27:0] w1;
    string       tag;
  } item_t;
  item_t exp_q[$];
  logic fmt_model = 1'b0;

  // driver: wait for the strobe cycle, drive, push expectation
  task automatic send(input logic [23:0] ev, input logic [23:0] od, input logic [1:0] de,
                      input logic fs, input logic fb, input string tag);
    item_t it;
    do @(negedge clk_fast); while (!pix_ce);
    pix_rgb = {od, ev};
    pix_de = de;
    fmt_sel = fs;
    frame_blank = fb;
    if (fb) fmt_model = fs;
    it.w0 = expect_word(ev, de[0], fmt_model);
    it.w1 = expect_word(od, de[1], fmt_model);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: reassemble frames and compare
  int mi = -1;
  int cyc = 0;
  int last_ce = -1;
  logic [27:0] got0, got1;
  logic [6:0] gclk0, gclk1;
  always @(negedge clk_fast) begin
    item_t it;
    if (rst_n && !done) begin
      cyc++;
      if (mi >= 0) begin
        for (int k = 0; k < 4; k++) begin
          got0[7*k + mi] = ser_data[k];
          got1[7*k + mi] = ser_data[4 + k];
        end
        gclk0[mi] = ser_clk[0];
        gclk1[mi] = ser_clk[1];
        mi++;
        if (mi == 7) begin
          mi = -1;
          check(gclk0 == 7'b1100011, "R6 link0 clock", 64'(gclk0), 64'(7'b1100011));
          check(gclk1 == 7'b1100011, "R6 link1 clock", 64'(gclk1), 64'(7'b1100011));
          check(got0[25:23] == 3'b000 && got1[25:23] == 3'b000, "R5 reserved",
                64'({got1[25:23], got0[25:23]}), 64'(0));
          if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            check(got0 == it.w0, {it.tag, " link0"}, 64'(got0), 64'(it.w0));
            check(got1 == it.w1, {it.tag, " link1 (R10)"}, 64'(got1), 64'(it.w1));
          end
        end
      end
      if (pix_ce) begin
        if (last_ce >= 0) check(cyc - last_ce == 7, "R7 strobe period", 64'(cyc - last_ce), 64'(7));
        last_ce = cyc;
        mi = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_fast);
    check(ser_data == 8'h00 && ser_clk == 2'b00 && !pix_ce, "R9 in reset",
          64'({pix_ce, ser_clk, ser_data}), 64'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk_fast);
    check(ser_data == 8'h00 && ser_clk == 2'b00 && !pix_ce, "R9 after reset",
          64'({pix_ce, ser_clk, ser_data}), 64'(0));
    // R2: standard arrangement, blanking with select 0
    send(24'h000000, 24'hFFFFFF, 2'b00, 1'b0, 1'b1, "R2 zero/ones");
    send(24'hA5C33C, 24'h5A3CC3, 2'b11, 1'b0, 1'b1, "R2 mixed");
    send(24'h800000, 24'h000001, 2'b01, 1'b0, 1'b0, "R2 red msb");
    send(24'h008000, 24'h000080, 2'b10, 1'b0, 1'b0, "R4 de split");
    // R1: single-slot patterns expose lane and bit order
    send(24'h010000, 24'h000100, 2'b00, 1'b0, 1'b0, "R1 first slot");
    send(24'h000040, 24'h000002, 2'b00, 1'b0, 1'b0, "R1 last lanes");
    // R8: select ignored outside blanking
    send(24'h123456, 24'h654321, 2'b11, 1'b1, 1'b0, "R8 ignored high");
    send(24'hC0C0C0, 24'h030303, 2'b01, 1'b1, 1'b0, "R8 still standard");
    // R3: shifted arrangement taken in blanking
    send(24'hC0C0C0, 24'h030303, 2'b11, 1'b1, 1'b1, "R3 shifted");
    send(24'hA5C33C, 24'h5A3CC3, 2'b10, 1'b1, 1'b0, "R3 held");
    send(24'h818181, 24'h7E7E7E, 2'b01, 1'b0, 1'b0, "R8 ignored low");
    send(24'hFFFFFF, 24'h000000, 2'b11, 1'b0, 1'b1, "R8 back to standard");
    send(24'hC0C0C0, 24'h030303, 2'b00, 1'b0, 1'b0, "R2 after switch");
    repeat (20) @(negedge clk_fast);
    check(exp_q.size() == 0, "R1 all frames seen", 64'(exp_q.size()), 64'(0));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog R7 actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule